// File: doc/BRIEF.md
# Oscillator Period Capture Timer

This block measures the period of a slow, free-running oscillator against a fast system clock. A timer advances once every twelve system clocks while a run control is high. The slow oscillator is brought into the system clock domain through a short synchronizer, and its rising edges drive a divide-by-eight counter. Each time that counter wraps, the running timer value is copied into a capture register and a sticky flag is raised. The flag drives an interrupt request whenever the interrupt enable is high.

Software reads two successive capture values and takes their difference modulo 2^16. That difference is the number of prescaled ticks in eight slow periods. The frequency arithmetic is left to software. The block has a single clock domain, and the slow oscillator is treated as a data input.

Top module: `osc_period_capture`

## Requirements
- R1: While `run_i` is high, `count_o` advances by exactly one every 12 system clocks. After k rising edges with run high, counting from reset, `count_o` equals floor(k/12).
- R2: With the slow oscillator running at a steady period of P system clocks, two successive captures differ by 8·P/12 counts when that quotient is exact. With P = 748, which is 24.5 MHz against 32.768 kHz, they differ by 498 or 499.
- R3: While `cap_en_i` is low, no capture takes place. `capture_o` and `flag_o` keep their values, and the divide-by-eight counter is held at zero, so that counting restarts when capture is enabled again.
- R4: With capture enabled, a capture happens on every 8th synchronized rising edge of `slow_osc_i`, and on no other edge. The edge takes effect on the third system clock rising edge after the slow input rises.
- R5: On a capture, `capture_o` takes the value `count_o` held in the capture cycle, before any increment made in that same cycle.
- R6: `flag_o` is set by a capture and stays set until a one-cycle `flag_clr_i` pulse. After that pulse it reads 0 on the following cycle.
- R7: If `flag_clr_i` and a capture fall in the same cycle, the capture wins and `flag_o` remains 1.
- R8: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R9: Reset (`rst_ni` low) clears the timer, the prescaler, the divide-by-eight counter, the synchronizer, `capture_o` and `flag_o`.
- R10: While `run_i` is low, both `count_o` and the prescaler phase hold. The prescaler phase is not lost: 24 clocks with run high after a pause add exactly 2 to `count_o`.
- R11: The timer wraps from its all-ones value to zero without stopping. The count is always floor(k/12) modulo 2^TMR_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_osc_i | input | 1 | Slow oscillator, asynchronous to clk_i |
| run_i | input | 1 | Timer and prescaler advance while high |
| cap_en_i | input | 1 | Capture mode enable |
| irq_en_i | input | 1 | Interrupt request enable |
| flag_clr_i | input | 1 | One-cycle pulse that clears the flag |
| count_o | output | TMR_W | Live timer value |
| capture_o | output | TMR_W | Timer value taken at the last capture |
| flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: a flag-clear pulse and a capture caused by the eighth slow edge. They can also meet a timer increment in the capture cycle. The bench drives the slow input by hand and counts three clocks from its rising edge to find the capture cycle, then places the clear pulse exactly there. It then expects the flag to stay set. Each capture value is compared with the count the bench sampled one cycle earlier. The capture must therefore hold the value from before the increment even when a prescaler tick falls on the same edge.

// File: rtl/osc_cap_pkg.sv
package osc_cap_pkg;
  localparam int TMR_W_DEF   = 16;
  localparam int PRESC_DEF   = 12;
  localparam int EVT_DIV_DEF = 8;
  localparam int SYNC_DEF    = 2;

  function automatic int cnt_w(input int div);
    return (div < 2) ? 1 : $clog2(div);
  endfunction
endpackage

// File: rtl/occ_sync_edge.sv
module occ_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // last synchronized stage vs one extra delay stage
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/occ_prescaler.sv
module occ_prescaler import osc_cap_pkg::*; #(
  parameter int DIV = PRESC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/occ_event_div.sv
module occ_event_div import osc_cap_pkg::*; #(
  parameter int DIV = EVT_DIV_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ev_i,
  output logic wrap_o
);
  localparam int CW = cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = ev_i && !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (ev_i)   cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/occ_timer.sv
module occ_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         snap_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] cnt_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // pre-increment value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (snap_i) snap_q <= cnt_q;
  end

  assign count_o = cnt_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/osc_period_capture.sv
module osc_period_capture import osc_cap_pkg::*; #(
  parameter int TMR_W       = TMR_W_DEF,
  parameter int PRESC_DIV   = PRESC_DEF,
  parameter int EVT_DIV     = EVT_DIV_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_osc_i,
  input  logic             run_i,
  input  logic             cap_en_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [TMR_W-1:0] count_o,
  output logic [TMR_W-1:0] capture_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic slow_rise, tick, cap_evt, flag_q;

  occ_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (slow_osc_i),
    .rise_o(slow_rise)
  );

  occ_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .tick_o(tick)
  );

  occ_event_div #(.DIV(EVT_DIV)) u_evdiv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(!cap_en_i),
    .ev_i  (slow_rise),
    .wrap_o(cap_evt)
  );

  occ_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .snap_i (cap_evt),
    .count_o(count_o),
    .snap_o (capture_o)
  );

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (cap_evt)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/osc_period_capture_chk.sv
module osc_period_capture_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         cap_en_i,
  input logic         flag_clr_i,
  input logic         cap_evt_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] capture_i,
  input logic         flag_i
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_i));

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (count_i == $past(count_i)) || (count_i == W'($past(count_i) + 1'b1)));

  p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(capture_i));

  p_snap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> capture_i == $past(count_i));

  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !flag_clr_i |=> flag_i);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !cap_evt_i |=> !flag_i);

  p_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> flag_i);
endmodule

bind osc_period_capture osc_period_capture_chk #(.W(TMR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .cap_en_i  (cap_en_i),
  .flag_clr_i(flag_clr_i),
  .cap_evt_i (cap_evt),
  .count_i   (count_o),
  .capture_i (capture_o),
  .flag_i    (flag_o)
);

// File: tb/tb_osc_period_capture.sv
`timescale 1ns/1ps
module tb_osc_period_capture;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slow_osc_i = 1'b0;
  logic run_i = 1'b0, cap_en_i = 1'b0, irq_en_i = 1'b0, flag_clr_i = 1'b0;
  logic [15:0] count_o, capture_o;
  logic flag_o, irq_o;
  logic [7:0] count_s, capture_s;
  logic flag_s, irq_s;

  always #10 clk_i = ~clk_i;

  osc_period_capture dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_osc_i(slow_osc_i), .run_i(run_i),
    .cap_en_i(cap_en_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .capture_o(capture_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  osc_period_capture #(.TMR_W(8)) dut_small (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_osc_i(slow_osc_i), .run_i(run_i),
    .cap_en_i(cap_en_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .count_o(count_s), .capture_o(capture_s), .flag_o(flag_s), .irq_o(irq_s)
  );

  int n_chk = 0, n_fail = 0;
  longint ncyc = 0, c0 = 0;
  int slow_per = 0, phase = 0, edges_since = 0, ncap = 0, skip = 99;
  logic slow_level = 1'b0;
  logic [15:0] last_cap = '0, prev_cnt = '0;
  int lo = 0, hi = 65535;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    logic nv;
    @(negedge clk_i);
    ncyc++;
    if (capture_o != last_cap) begin
      chk(capture_o == prev_cnt, "R5 capture value", capture_o, prev_cnt);
      if (skip == 0) begin
        chk(edges_since == 8, "R4 edges per capture", edges_since, 8);
        chk(16'(capture_o - last_cap) >= lo && 16'(capture_o - last_cap) <= hi,
            "R2 capture difference", 16'(capture_o - last_cap), lo);
      end else if (skip < 99) skip--;
      last_cap = capture_o;
      edges_since = 0;
      ncap++;
    end
    prev_cnt = count_o;
    if (slow_per > 0) begin
      phase = (phase + 1) % slow_per;
      nv = (phase < slow_per / 2);
    end else nv = slow_level;
    if (nv && !slow_osc_i) edges_since++;
    slow_osc_i = nv;
  endtask

  task automatic check_count();
    longint k = (ncyc - c0) / 12;
    chk(count_o == 16'(k), "R1 count", count_o, k & 16'hFFFF);
    chk(count_s == 8'(k), k >= 256 ? "R11 wrap count" : "R1 small count", count_s, k & 8'hFF);
  endtask

  task automatic run_slow(input int per, input int lo_v, input int hi_v, input int n);
    slow_per = per; phase = 0; lo = lo_v; hi = hi_v; skip = 2;
    for (int i = 0; i < n; i++) begin
      step();
      if (i % 53 == 0) check_count();
    end
  endtask

  task automatic pulse();
    slow_level = 1'b1; step(); step(); step();
    slow_level = 1'b0; step(); step(); step();
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cap0;
    logic [15:0] v;
    step(); step(); step();
    rst_ni = 1'b1;
    step();
    chk(count_o == 0, "R9 count after reset", count_o, 0);
    chk(capture_o == 0, "R9 capture after reset", capture_o, 0);
    chk(flag_o == 0, "R9 flag after reset", flag_o, 0);
    chk(irq_o == 0, "R9 irq after reset", irq_o, 0);
    chk(count_s == 0, "R9 small count after reset", count_s, 0);

    c0 = ncyc; run_i = 1'b1;
    slow_per = 24;
    for (int i = 0; i < 400; i++) begin
      step();
      if (i % 37 == 0) check_count();
    end
    chk(ncap == 0, "R3 no capture while disabled", ncap, 0);
    chk(capture_o == 0, "R3 capture held", capture_o, 0);
    chk(flag_o == 0, "R3 flag held", flag_o, 0);

    cap_en_i = 1'b1;
    run_slow(24, 16, 16, 24 * 8 * 5);
    chk(ncap >= 4, "R4 captures at P=24", ncap, 4);
    cap0 = ncap;
    run_slow(30, 20, 20, 30 * 8 * 5);
    chk(ncap - cap0 >= 4, "R4 captures at P=30", ncap - cap0, 4);
    cap0 = ncap;
    run_slow(748, 498, 499, 748 * 8 * 4);
    chk(ncap - cap0 >= 3, "R2 captures at P=748", ncap - cap0, 3);

    // manual slow edges: collision of clear and capture
    slow_per = 0; slow_level = 1'b0; skip = 99;
    cap_en_i = 1'b0; repeat (4) step();
    cap_en_i = 1'b1; repeat (2) step();
    chk(flag_o == 1, "R6 flag sticky without clear", flag_o, 1);
    cap0 = ncap;
    for (int i = 0; i < 7; i++) pulse();
    chk(ncap == cap0, "R4 no capture before 8th edge", ncap - cap0, 0);
    slow_level = 1'b1; step(); step(); step();
    flag_clr_i = 1'b1; step(); flag_clr_i = 1'b0;
    chk(flag_o == 1, "R7 capture beats clear", flag_o, 1);
    slow_level = 1'b0; step(); step();
    chk(ncap == cap0 + 1, "R4 capture on 8th edge", ncap - cap0, 1);

    flag_clr_i = 1'b1; step(); flag_clr_i = 1'b0;
    chk(flag_o == 0, "R6 clear drops flag", flag_o, 0);
    irq_en_i = 1'b1; #1;
    chk(irq_o == 0, "R8 irq low with flag low", irq_o, 0);
    for (int i = 0; i < 8; i++) pulse();
    chk(flag_o == 1, "R4 flag after 8 more edges", flag_o, 1);
    chk(irq_o == 1, "R8 irq high", irq_o, 1);
    irq_en_i = 1'b0; #1;
    chk(irq_o == 0, "R8 irq masked", irq_o, 0);

    run_i = 1'b0; step();
    v = count_o;
    repeat (100) step();
    chk(count_o == v, "R10 count held", count_o, v);
    run_i = 1'b1;
    repeat (24) step();
    chk(count_o == 16'(v + 2), "R10 prescaler phase kept", count_o, 16'(v + 2));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule